// File: doc/BRIEF.md
# Shared-Generator PWM Output Bank

The block keeps a small pool of waveform generators and lets any of 33 output pins borrow one of them. Each generator holds an 8-bit period, counted in ticks of a common prescaled strobe, and an 8-bit duty level on a 0..255 scale. Every pin has a 4-bit map entry that either connects it to one generator or holds it low. Sixteen pins leave the block as direct GPIO outputs. The other seventeen form a parallel vector that a separate serial expander consumes.

Software programs the generators and the map through a single-cycle register write port. A map write changes the pin on the next clock. Generator writes go into shadow registers. Each generator copies its shadow values into its active settings only when its current period ends, so a running period is always finished with the values it started with. Each generator is a three-state machine: GEN_OFF (no period loaded, output low), GEN_HIGH (inside the duty portion) and GEN_LOW (the rest of the period). On every tick in GEN_OFF, and on the last tick of a period in the other states, the machine takes the wrap transition. This transition loads the shadow values and enters GEN_OFF if the period is 0, GEN_HIGH if the duty is non-zero, and GEN_LOW otherwise. On any other tick, the phase advances and the machine moves from GEN_HIGH to GEN_LOW (or stays where it is) according to the duty comparison.

Top module: `pwm_bank_top`

## Requirements
- R1: After reset all 16 GPIO outputs and all 17 expander outputs are low, and every generator is in GEN_OFF.
- R2: A generator with period P (1..255) repeats every P ticks, and one tick lasts TICK_CLKS clock cycles, so a pin's waveform repeats every P*TICK_CLKS cycles.
- R3: Polarity is normal. Within a period, the output is high during tick phase k (k = 0..P-1) exactly when 255*k < duty*P. It is therefore high first and low afterwards.
- R4: Duty 255 keeps a mapped pin high continuously.
- R5: Duty 0 keeps a mapped pin low continuously.
- R6: Period 0 puts the generator in GEN_OFF, and its output is low whatever the duty is.
- R7: Pin n has a 4-bit map entry in word 4 + n/8, bits 4*(n%8)+3 down to 4*(n%8). Bit 3 of the entry enables the pin and bits 2:0 select the generator. A disabled entry drives the pin low. A map write is visible on the pin from the clock after the write.
- R8: Pins mapped to the same generator carry identical waveforms.
- R9: The period of generator g is byte g%4 of word g/4 (words 0-1). Its duty is byte g%4 of word 2 + g/4 (words 2-3). A write replaces only the fields in the addressed word.
- R10: A new period or duty written while a generator runs takes effect only at that generator's next period wrap. The period already in progress completes with the old values.
- R11: Pins 0-15 drive gpio_o[15:0] and pins 16-32 drive sipo_o[16:0] in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| gpio_o | output | 16 | Direct pin outputs, pins 0-15 |
| sipo_o | output | 17 | Parallel vector for the serial expander, pins 16-32 |

## Verification
The hardest case to reach from the ports is a shadow write that arrives partway through a running period. The period in progress must then end with the old timing, and the following period must use the new values. To produce it, the stimulus queues two expected waveforms on the scoreboard: the old period/high time and the new one. It then waits until the monitor has locked onto a rising edge of the observed pin, which marks the start of a period, and a few cycles later writes the new period and duty words. The scoreboard measures both the high time and the full length of two consecutive periods. A change that leaks into the middle of a period therefore shows up as a wrong length in the first measurement.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int BYTE_W       = 8;
    localparam int DATA_W       = 32;
    localparam int GEN_PER_WORD = DATA_W / BYTE_W;
    localparam int MAP_W        = 4;
    localparam int MAP_PER_WORD = DATA_W / MAP_W;
    localparam int SEL_W        = MAP_W - 1;
    localparam int MAX_GEN      = 1 << SEL_W;
    localparam logic [BYTE_W-1:0] DUTY_FULL = 8'd255;

    typedef enum logic [1:0] {
        GEN_OFF  = 2'd0,
        GEN_HIGH = 2'd1,
        GEN_LOW  = 2'd2
    } gen_state_e;
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
    parameter int TICK_CLKS = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CLKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_GEN = 8,
    parameter int NUM_PIN = 33,
    parameter int ADDR_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [NUM_GEN-1:0][BYTE_W-1:0]  sh_per_o,
    output logic [NUM_GEN-1:0][BYTE_W-1:0]  sh_duty_o,
    output logic [NUM_PIN-1:0]              map_en_o,
    output logic [NUM_PIN-1:0][SEL_W-1:0]   map_sel_o
);
    localparam int GEN_WORDS = (NUM_GEN + GEN_PER_WORD - 1) / GEN_PER_WORD;
    localparam int PER_BASE  = 0;
    localparam int DUTY_BASE = GEN_WORDS;
    localparam int MAP_BASE  = 2 * GEN_WORDS;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_per_o  <= '0;
            sh_duty_o <= '0;
            map_en_o  <= '0;
            map_sel_o <= '0;
        end else if (wr_en) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                if (wr_addr == ADDR_W'(PER_BASE + g / GEN_PER_WORD))
                    sh_per_o[g] <= wr_data[(g % GEN_PER_WORD)*BYTE_W +: BYTE_W];
                if (wr_addr == ADDR_W'(DUTY_BASE + g / GEN_PER_WORD))
                    sh_duty_o[g] <= wr_data[(g % GEN_PER_WORD)*BYTE_W +: BYTE_W];
            end
            for (int p = 0; p < NUM_PIN; p++) begin
                if (wr_addr == ADDR_W'(MAP_BASE + p / MAP_PER_WORD)) begin
                    map_en_o[p]  <= wr_data[(p % MAP_PER_WORD)*MAP_W + SEL_W];
                    map_sel_o[p] <= wr_data[(p % MAP_PER_WORD)*MAP_W +: SEL_W];
                end
            end
        end
    end
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [BYTE_W-1:0] sh_per_i,
    input  logic [BYTE_W-1:0] sh_duty_i,
    output logic              wave_o,
    output logic [BYTE_W-1:0] act_per_o,
    output logic [BYTE_W-1:0] act_duty_o,
    output logic [BYTE_W-1:0] phase_o
);
    gen_state_e        state_q, state_d;
    logic [BYTE_W-1:0] per_q, per_d;
    logic [BYTE_W-1:0] duty_q, duty_d;
    logic [BYTE_W-1:0] phase_q, phase_d;
    logic              wrap;

    function automatic logic in_high(input logic [BYTE_W-1:0] ph,
                                     input logic [BYTE_W-1:0] du,
                                     input logic [BYTE_W-1:0] pe);
        return (16'(ph) * 16'(DUTY_FULL)) < (16'(du) * 16'(pe));
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GEN_OFF;
            per_q   <= '0;
            duty_q  <= '0;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            per_q   <= per_d;
            duty_q  <= duty_d;
            phase_q <= phase_d;
        end
    end

    assign wrap = (state_q == GEN_OFF) || (phase_q == per_q - 1'b1);

    always_comb begin
        state_d = state_q;
        per_d   = per_q;
        duty_d  = duty_q;
        phase_d = phase_q;
        if (tick_i) begin
            if (wrap) begin
                per_d   = sh_per_i;
                duty_d  = sh_duty_i;
                phase_d = '0;
                if (sh_per_i == '0)
                    state_d = GEN_OFF;
                else if (sh_duty_i != '0)
                    state_d = GEN_HIGH;
                else
                    state_d = GEN_LOW;
            end else begin
                phase_d = phase_q + 1'b1;
                state_d = in_high(phase_d, duty_q, per_q) ? GEN_HIGH : GEN_LOW;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            GEN_HIGH: wave_o = 1'b1;
            GEN_LOW:  wave_o = 1'b0;
            GEN_OFF:  wave_o = 1'b0;
            default:  wave_o = 1'b0;
        endcase
    end

    assign act_per_o  = per_q;
    assign act_duty_o = duty_q;
    assign phase_o    = phase_q;
endmodule

// File: rtl/pwm_pin_route.sv
module pwm_pin_route
    import pwm_bank_pkg::*;
#(
    parameter int NUM_GEN = 8,
    parameter int NUM_PIN = 33
) (
    input  logic [NUM_GEN-1:0]            wave_i,
    input  logic [NUM_PIN-1:0]            map_en_i,
    input  logic [NUM_PIN-1:0][SEL_W-1:0] map_sel_i,
    output logic [NUM_PIN-1:0]            pin_o
);
    logic [MAX_GEN-1:0] wave_ext;

    always_comb begin
        wave_ext = '0;
        wave_ext[NUM_GEN-1:0] = wave_i;
    end

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        assign pin_o[p] = map_en_i[p] & wave_ext[map_sel_i[p]];
    end
endmodule

// File: rtl/pwm_bank_top.sv
module pwm_bank_top
    import pwm_bank_pkg::*;
#(
    parameter int NUM_GEN   = 8,
    parameter int NUM_GPIO  = 16,
    parameter int NUM_SIPO  = 17,
    parameter int ADDR_W    = 4,
    parameter int TICK_CLKS = 500000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_GPIO-1:0] gpio_o,
    output logic [NUM_SIPO-1:0] sipo_o
);
    localparam int NUM_PIN = NUM_GPIO + NUM_SIPO;

    logic                           tick;
    logic [NUM_GEN-1:0][BYTE_W-1:0] sh_per, sh_duty;
    logic [NUM_GEN-1:0][BYTE_W-1:0] act_per, act_duty, phase;
    logic [NUM_GEN-1:0]             gen_wave;
    logic [NUM_PIN-1:0]             map_en;
    logic [NUM_PIN-1:0][SEL_W-1:0]  map_sel;
    logic [NUM_PIN-1:0]             pins;

    pwm_tick_div #(.TICK_CLKS(TICK_CLKS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    pwm_cfg_regs #(.NUM_GEN(NUM_GEN), .NUM_PIN(NUM_PIN), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sh_per_o(sh_per), .sh_duty_o(sh_duty), .map_en_o(map_en), .map_sel_o(map_sel)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        pwm_wave_gen u_gen (
            .clk(clk), .rst_n(rst_n), .tick_i(tick),
            .sh_per_i(sh_per[g]), .sh_duty_i(sh_duty[g]),
            .wave_o(gen_wave[g]), .act_per_o(act_per[g]),
            .act_duty_o(act_duty[g]), .phase_o(phase[g])
        );
    end

    pwm_pin_route #(.NUM_GEN(NUM_GEN), .NUM_PIN(NUM_PIN)) u_route (
        .wave_i(gen_wave), .map_en_i(map_en), .map_sel_i(map_sel), .pin_o(pins)
    );

    assign gpio_o = pins[NUM_GPIO-1:0];
    assign sipo_o = pins[NUM_PIN-1:NUM_GPIO];
endmodule

// File: rtl/pwm_bank_checker.sv
module pwm_bank_checker
    import pwm_bank_pkg::*;
#(
    parameter int NUM_GEN  = 8,
    parameter int NUM_GPIO = 16,
    parameter int ADDR_W   = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_en,
    input logic [ADDR_W-1:0]              wr_addr,
    input logic [DATA_W-1:0]              wr_data,
    input logic [NUM_GPIO-1:0]            gpio_o,
    input logic                           tick,
    input logic [NUM_GEN-1:0]             gen_wave,
    input logic [NUM_GEN-1:0][BYTE_W-1:0] act_per,
    input logic [NUM_GEN-1:0][BYTE_W-1:0] act_duty,
    input logic [NUM_GEN-1:0][BYTE_W-1:0] phase
);
    localparam int MAP_BASE = 2 * ((NUM_GEN + GEN_PER_WORD - 1) / GEN_PER_WORD);

    // R7: clearing the enable bit of pin 0 lowers the pin on the next clock
    a_r7_map_disable_next: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(MAP_BASE) && !wr_data[SEL_W]) |=> !gpio_o[0]);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        // R10: active settings move only on a wrapping tick
        a_r10_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
            !(tick && (act_per[g] == '0 || phase[g] == act_per[g] - 1'b1))
            |=> ($stable(act_per[g]) && $stable(act_duty[g])));

        // R2: the phase never reaches the period length
        a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            (act_per[g] != '0) |-> (phase[g] < act_per[g]));

        // R6: a zero period keeps the generator output low
        a_r6_off_is_low: assert property (@(posedge clk) disable iff (!rst_n)
            (act_per[g] == '0) |-> !gen_wave[g]);

        // R4: a full duty level keeps a running generator high
        a_r4_full_is_high: assert property (@(posedge clk) disable iff (!rst_n)
            (act_per[g] != '0 && act_duty[g] == DUTY_FULL) |-> gen_wave[g]);
    end
endmodule

bind pwm_bank_top pwm_bank_checker #(
    .NUM_GEN(NUM_GEN), .NUM_GPIO(NUM_GPIO), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gpio_o(gpio_o), .tick(tick), .gen_wave(gen_wave),
    .act_per(act_per), .act_duty(act_duty), .phase(phase)
);

// File: tb/sim_pwm_bank_top.sv
module sim_pwm_bank_top;
    localparam int TICK = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] gpio_o;
    logic [16:0] sipo_o;
    logic [32:0] allp;

    pwm_bank_top #(.TICK_CLKS(TICK)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gpio_o(gpio_o), .sipo_o(sipo_o)
    );

    assign allp = {sipo_o, gpio_o};
    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct { int per; int hi; string req; } exp_t;
    exp_t sb_q[$];
    int   mon_sel = 0;
    int   mon_st  = 0;

    logic [31:0] per_w [2];
    logic [31:0] duty_w [2];
    logic [31:0] map_w [5];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R9: period byte g%4 of word g/4, duty byte g%4 of word 2+g/4
    task automatic set_gen(input int g, input int p, input int d);
        per_w[g/4][8*(g%4) +: 8]  = 8'(p);
        duty_w[g/4][8*(g%4) +: 8] = 8'(d);
        wr(4'(g/4), per_w[g/4]);
        wr(4'(2 + g/4), duty_w[g/4]);
    endtask

    // R7: entry of pin n in word 4+n/8, nibble n%8, {enable, select[2:0]}
    task automatic set_map(input int pin, input bit en, input int sel);
        map_w[pin/8][4*(pin%8) +: 4] = {en, 3'(sel)};
        wr(4'(4 + pin/8), map_w[pin/8]);
    endtask

    // R3: count of tick phases k with 255*k < duty*period
    task automatic expect_wave(input int p, input int d, input string req);
        exp_t e;
        int hi = 0;
        for (int k = 0; k < p; k++) if (255*k < d*p) hi++;
        e.per = p * TICK; e.hi = hi * TICK; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic level_hold(input int pin, input logic lvl, input int n,
                              input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (allp[pin] !== lvl) bad++;
        end
        check(bad == 0, req, $sformatf("pin %0d off-level samples", pin), bad, 0);
    endtask

    // scoreboard monitor: measures high time and period from rise to rise
    initial begin
        logic prev = 1'b0;
        logic cur;
        int hc = 0;
        int tc = 0;
        forever begin
            @(negedge clk);
            cur = allp[mon_sel];
            if (sb_q.size() == 0) mon_st = 0;
            else begin
                case (mon_st)
                    0: if (!prev && cur) begin mon_st = 1; hc = 1; tc = 1; end
                    1: begin tc++; if (cur) hc++; else mon_st = 2; end
                    default: begin
                        if (cur) begin
                            check(tc == sb_q[0].per, sb_q[0].req, "period clocks", tc, sb_q[0].per);
                            check(hc == sb_q[0].hi, sb_q[0].req, "high clocks", hc, sb_q[0].hi);
                            void'(sb_q.pop_front());
                            hc = 1; tc = 1; mon_st = 1;
                        end else tc++;
                    end
                endcase
            end
            prev = cur;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int bad;
        for (int i = 0; i < 2; i++) begin per_w[i] = '0; duty_w[i] = '0; end
        for (int i = 0; i < 5; i++) map_w[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(gpio_o == 16'h0, "R1", "gpio after reset", int'(gpio_o), 0);
        check(sipo_o == 17'h0, "R1", "sipo after reset", int'(sipo_o), 0);

        // R2 R3: gen0 P=10 duty=128 on pin 0
        set_map(0, 1'b1, 0);
        mon_sel = 0;
        expect_wave(10, 128, "R3");
        expect_wave(10, 128, "R2");
        set_gen(0, 10, 128);
        drain();

        // R11 R9: gen3 (byte 3 of word 0) on expander pin 4
        set_map(20, 1'b1, 3);
        mon_sel = 20;
        expect_wave(5, 51, "R11");
        expect_wave(5, 51, "R9");
        set_gen(3, 5, 51);
        drain();

        // R11 R9: gen7 on the last expander pin
        set_map(32, 1'b1, 7);
        mon_sel = 32;
        expect_wave(7, 100, "R11");
        set_gen(7, 7, 100);
        drain();

        // R8: pin 5 shares gen0 with pin 0
        set_map(5, 1'b1, 0);
        bad = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (gpio_o[5] !== gpio_o[0]) bad++;
        end
        check(bad == 0, "R8", "shared pin mismatches", bad, 0);

        // R4: full duty
        set_gen(1, 4, 255);
        set_map(1, 1'b1, 1);
        repeat (40) @(negedge clk);
        level_hold(1, 1'b1, 64, "R4");

        // R5: zero duty
        set_gen(2, 6, 0);
        set_map(2, 1'b1, 2);
        repeat (40) @(negedge clk);
        level_hold(2, 1'b0, 64, "R5");

        // R6: zero period with full duty
        set_gen(4, 0, 255);
        set_map(6, 1'b1, 4);
        repeat (40) @(negedge clk);
        level_hold(6, 1'b0, 64, "R6");

        // R7: disabled entry pointing at a high generator, then toggle
        set_map(3, 1'b0, 1);
        level_hold(3, 1'b0, 20, "R7");
        set_map(3, 1'b1, 1);
        check(gpio_o[3] == 1'b1, "R7", "pin 3 after enable", int'(gpio_o[3]), 1);
        set_map(3, 1'b0, 1);
        check(gpio_o[3] == 1'b0, "R7", "pin 3 after disable", int'(gpio_o[3]), 0);

        // R10: rewrite gen0 in the middle of a running period
        mon_sel = 0;
        expect_wave(10, 128, "R10");
        expect_wave(6, 85, "R10");
        wait (mon_st == 1);
        repeat (3) @(negedge clk);
        set_gen(0, 6, 85);
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule